// File: doc/BRIEF.md
# Per-Block Program/Erase Lock Manager

This block keeps a lock state for every erase block of a flash array and decides whether program and erase are allowed in a given block. Software changes the state with two-cycle command sequences: a setup code (0x60) arms the sequencer, and the next command cycle carries the action code and the target block. The write-protect pin level is sampled on every clock. It decides whether a block's lock-down bit is enforced.

Each block stores a lock bit and a lock-down bit. The state code for a block is {wpPin, lockdown, lock}. With the pin low and lock-down set, a block cannot be unlocked. Raising the pin suspends enforcement, so the block can be unlocked. Lowering the pin again restores enforcement of the lock-down bit, which was never cleared. Only reset clears lock-down. A query port returns the state code, the status bits and the allow decision for any block on the same cycle. A malformed sequence raises a one-cycle error strobe, which the surrounding status logic turns into its sequence-error flags.

Top module: `blk_lock_mgr`

## Requirements
- R1: After reset every block reads lock=1 and lockdown=0 (qryStatus = 2'b01), whatever the level of wpPin.
- R2: A setup cycle (0x60) followed by a command cycle carrying 0x01 sets the lock bit of the block on cmdBlock and no other block.
- R3: Setup followed by 0xD0 clears the lock bit of the addressed block, unless that block's lockdown bit is 1 while wpPin is 0, in which case nothing changes.
- R4: Setup followed by 0x2F sets both the lock bit and the lockdown bit of the addressed block, whatever the wpPin level.
- R5: For a block with lock=1 and lockdown=1 while wpPin is 0, no command sequence changes its state.
- R6: The lockdown bit is cleared only by reset. With wpPin at 1 a locked-down block can be unlocked. When wpPin returns to 0, lockdown is enforced again.
- R7: After a setup cycle, a command cycle whose code is not 0x01, 0xD0 or 0x2F (including a second 0x60) changes no state. It raises seqErr for exactly the one cycle that follows that command edge, and it disarms the sequencer.
- R8: While programSuspended is 1 on the second cycle of a sequence, a valid action code changes no state and raises no seqErr.
- R9: The query outputs are combinational from the state of block qryBlock. qryCode = {wpPin, lockdown, lock}. qryStatus bit 0 holds lock and bit 1 holds lockdown. qryAllow = 1 exactly when lock = 0.
- R10: A command cycle that does not follow a setup cycle changes no state and raises no seqErr. An armed sequencer stays armed through idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wpPin | input | 1 | Write-protect pin level (1 = high, lock-down relaxed) |
| cmdValid | input | 1 | A command cycle is present this clock |
| cmdCode | input | 8 | Command code |
| cmdBlock | input | BLK_W | Block addressed by the command cycle |
| programSuspended | input | 1 | A program operation is suspended; lock changes are refused |
| qryBlock | input | BLK_W | Block whose state is reported |
| qryCode | output | 3 | {wpPin, lockdown, lock} of qryBlock |
| qryStatus | output | 2 | {lockdown, lock} of qryBlock |
| qryAllow | output | 1 | Program/erase allowed in qryBlock |
| seqErr | output | 1 | One-cycle strobe for a bad code after setup |

## Verification
A state change lands on the clock edge that samples the second command cycle. Because the query path is combinational, the new code is visible in the half-cycle after that edge, and seqErr shows in that same half-cycle. The bench drives each command on a falling edge. It reads seqErr on the next falling edge and then sweeps qryBlock over every block with no command pending. A model of the lock and lock-down bits runs alongside, and each block is compared against it. A wpPin change appears in qryCode without any clock, so it is checked right after the pin is driven.

// File: rtl/lockmgr_pkg.sv
package lockmgr_pkg;
  localparam logic [7:0] OP_SETUP  = 8'h60;
  localparam logic [7:0] OP_LOCK   = 8'h01;
  localparam logic [7:0] OP_UNLOCK = 8'hD0;
  localparam logic [7:0] OP_DOWN   = 8'h2F;

  // strobes from the sequencer to the state array, valid for one edge
  typedef struct packed {
    logic setLock;
    logic clrLock;
    logic setDown;
  } lockStb_t;
endpackage

// File: rtl/lock_seq_ctrl.sv
module lock_seq_ctrl
  import lockmgr_pkg::*;
#(
  parameter int BLK_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [7:0]       cmdCode,
  input  logic [BLK_W-1:0] cmdBlock,
  input  logic             programSuspended,
  output lockStb_t         stb,
  output logic [BLK_W-1:0] tgtBlock,
  output logic             seqErr
);
  logic armed;
  logic armedNext;
  logic errNext;

  always_comb begin
    stb       = '0;
    errNext   = 1'b0;
    armedNext = armed;
    if (cmdValid) begin
      if (armed) begin
        armedNext = 1'b0;
        unique case (cmdCode)
          OP_LOCK:   stb.setLock = !programSuspended;
          OP_UNLOCK: stb.clrLock = !programSuspended;
          OP_DOWN: begin
            stb.setLock = !programSuspended;
            stb.setDown = !programSuspended;
          end
          default:   errNext = 1'b1;
        endcase
      end else begin
        armedNext = (cmdCode == OP_SETUP);
      end
    end
  end

  assign tgtBlock = cmdBlock;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed  <= 1'b0;
      seqErr <= 1'b0;
    end else begin
      armed  <= armedNext;
      seqErr <= errNext;
    end
  end
endmodule

// File: rtl/lock_state_array.sv
module lock_state_array
  import lockmgr_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int BLK_W      = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wpPin,
  input  lockStb_t         stb,
  input  logic [BLK_W-1:0] tgtBlock,
  input  logic [BLK_W-1:0] qryBlock,
  output logic [2:0]       qryCode,
  output logic [1:0]       qryStatus,
  output logic             qryAllow
);
  logic [NUM_BLOCKS-1:0] lockVec;
  logic [NUM_BLOCKS-1:0] downVec;

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
    logic hit;
    logic downActive;
    assign hit        = (tgtBlock == BLK_W'(g));
    assign downActive = downVec[g] && !wpPin;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lockVec[g] <= 1'b1;
        downVec[g] <= 1'b0;
      end else if (hit) begin
        if (stb.setLock)
          lockVec[g] <= 1'b1;
        else if (stb.clrLock && !downActive)
          lockVec[g] <= 1'b0;
        if (stb.setDown)
          downVec[g] <= 1'b1;
      end
    end
  end

  logic selLock;
  logic selDown;

  always_comb begin
    selLock = 1'b1;
    selDown = 1'b0;
    if (int'(qryBlock) < NUM_BLOCKS) begin
      selLock = lockVec[qryBlock];
      selDown = downVec[qryBlock];
    end
  end

  assign qryCode   = {wpPin, selDown, selLock};
  assign qryStatus = {selDown, selLock};
  assign qryAllow  = !selLock;
endmodule

// File: rtl/blk_lock_mgr.sv
module blk_lock_mgr
  import lockmgr_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int BLK_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wpPin,
  input  logic             cmdValid,
  input  logic [7:0]       cmdCode,
  input  logic [BLK_W-1:0] cmdBlock,
  input  logic             programSuspended,
  input  logic [BLK_W-1:0] qryBlock,
  output logic [2:0]       qryCode,
  output logic [1:0]       qryStatus,
  output logic             qryAllow,
  output logic             seqErr
);
  lockStb_t         stb;
  logic [BLK_W-1:0] tgtBlock;

  lock_seq_ctrl #(.BLK_W(BLK_W)) u_ctrl (
    .clk              (clk),
    .rstN             (rstN),
    .cmdValid         (cmdValid),
    .cmdCode          (cmdCode),
    .cmdBlock         (cmdBlock),
    .programSuspended (programSuspended),
    .stb              (stb),
    .tgtBlock         (tgtBlock),
    .seqErr           (seqErr)
  );

  lock_state_array #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_state (
    .clk       (clk),
    .rstN      (rstN),
    .wpPin     (wpPin),
    .stb       (stb),
    .tgtBlock  (tgtBlock),
    .qryBlock  (qryBlock),
    .qryCode   (qryCode),
    .qryStatus (qryStatus),
    .qryAllow  (qryAllow)
  );
endmodule

// File: rtl/blk_lock_mgr_chk.sv
module blk_lock_mgr_chk #(
  parameter int BLK_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             wpPin,
  input logic             programSuspended,
  input logic [BLK_W-1:0] qryBlock,
  input logic [1:0]       qryStatus,
  input logic             seqErr
);
  // R1
  reset_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (qryStatus == 2'b01));

  // R5
  down_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (qryStatus == 2'b11 && !wpPin) |=> (!$stable(qryBlock) || qryStatus == 2'b11));

  // R6
  down_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    qryStatus[1] |=> (!$stable(qryBlock) || qryStatus[1]));

  // R7
  err_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqErr |=> !seqErr);

  // R8
  psusp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    programSuspended |=> (!$stable(qryBlock) || $stable(qryStatus)));
endmodule

bind blk_lock_mgr blk_lock_mgr_chk #(.BLK_W(BLK_W)) u_chk (
  .clk              (clk),
  .rstN             (rstN),
  .wpPin            (wpPin),
  .programSuspended (programSuspended),
  .qryBlock         (qryBlock),
  .qryStatus        (qryStatus),
  .seqErr           (seqErr)
);

// File: tb/sim_blk_lock_mgr.sv
module sim_blk_lock_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;
  localparam int BW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wpPin = 1'b0;
  logic          cmdValid = 1'b0;
  logic [7:0]    cmdCode = 8'h00;
  logic [BW-1:0] cmdBlock = '0;
  logic          programSuspended = 1'b0;
  logic [BW-1:0] qryBlock = '0;
  logic [2:0]    qryCode;
  logic [1:0]    qryStatus;
  logic          qryAllow;
  logic          seqErr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic mLk [NB];
  logic mLd [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_lock_mgr #(.NUM_BLOCKS(NB)) u0 (
    .clk(clk), .rstN(rstN), .wpPin(wpPin), .cmdValid(cmdValid),
    .cmdCode(cmdCode), .cmdBlock(cmdBlock), .programSuspended(programSuspended),
    .qryBlock(qryBlock), .qryCode(qryCode), .qryStatus(qryStatus),
    .qryAllow(qryAllow), .seqErr(seqErr)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int b = 0; b < NB; b++) begin
      mLk[b] = 1'b1;
      mLd[b] = 1'b0;
    end
  endtask

  // R9: query sweep of every block against the model
  task automatic sweep(input string tag);
    for (int b = 0; b < NB; b++) begin
      qryBlock = BW'(b);
      #1;
      chk(tag, {qryAllow, qryStatus, 2'b00, qryCode},
          {!mLk[b], mLd[b], mLk[b], 2'b00, wpPin, mLd[b], mLk[b]});
    end
  endtask

  task automatic drive(input logic [7:0] code, input int blk, input logic ps);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdCode = code;
    cmdBlock = BW'(blk);
    programSuspended = ps;
    @(negedge clk);
    cmdValid = 1'b0;
    programSuspended = 1'b0;
  endtask

  task automatic pairCmd(input logic [7:0] code, input int blk, input logic ps);
    logic good;
    string tag;
    good = (code == 8'h01) || (code == 8'hD0) || (code == 8'h2F);
    drive(8'h60, blk, 1'b0);
    chk("R10 setup no err", {7'd0, seqErr}, 8'd0);
    drive(code, blk, ps);
    chk(good ? "R8 err" : "R7 err", {7'd0, seqErr}, {7'd0, !good});
    if (good && !ps) begin
      if (code == 8'h01) mLk[blk] = 1'b1;
      else if (code == 8'h2F) begin mLk[blk] = 1'b1; mLd[blk] = 1'b1; end
      else if (!(mLd[blk] && !wpPin)) mLk[blk] = 1'b0;
    end
    if (!good) tag = "R7 state";
    else if (ps) tag = "R8 state";
    else if (code == 8'h01) tag = "R2 state";
    else if (code == 8'h2F) tag = "R4 state";
    else tag = "R3 state";
    sweep(tag);
    @(negedge clk);
    chk("R7 err one cycle", {7'd0, seqErr}, 8'd0);
  endtask

  task automatic setWp(input logic v);
    @(negedge clk);
    wpPin = v;
    sweep("R6 wp level");
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    modelReset();
    sweep("R1 reset");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    sweep("R1 reset wp low");
    doReset();
    setWp(1'b1);
    doReset();
    setWp(1'b0);

    // directed lock-down walk on block 2
    pairCmd(8'hD0, 2, 1'b0);   // R3 unlock
    pairCmd(8'h2F, 2, 1'b0);   // R4 lock-down
    pairCmd(8'hD0, 2, 1'b0);   // R5 refused
    pairCmd(8'h01, 2, 1'b0);   // R5 no change
    setWp(1'b1);
    pairCmd(8'hD0, 2, 1'b0);   // R6 unlock with pin high
    setWp(1'b0);               // R6 virtual lock-down, still unlocked
    pairCmd(8'hD0, 2, 1'b0);   // R3 no-op
    pairCmd(8'h01, 2, 1'b0);   // R2 relock
    pairCmd(8'hD0, 2, 1'b0);   // R5 refused again
    pairCmd(8'h60, 2, 1'b0);   // R7 double setup
    pairCmd(8'hD0, 5, 1'b1);   // R8 refused during program suspend
    drive(8'hD0, 5, 1'b0);     // R10 stray unlock without setup
    chk("R10 stray no err", {7'd0, seqErr}, 8'd0);
    sweep("R10 stray state");
    doReset();                 // R6 reset clears lock-down

    // pseudo-random sweep
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      int blk;
      logic [7:0] vcode;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      blk = int'(lfsr[12:10]) % NB;
      case (lfsr[9:8])
        2'd0: vcode = 8'h01;
        2'd1: vcode = 8'hD0;
        2'd2: vcode = 8'h2F;
        default: vcode = 8'hD0;
      endcase
      if (i % 97 == 96) doReset();
      else begin
        case (lfsr[2:0])
          3'd0: setWp(!wpPin);
          3'd1: begin
            drive(lfsr[4] ? vcode : 8'h70, blk, 1'b0);
            chk("R10 stray no err", {7'd0, seqErr}, 8'd0);
            sweep("R10 stray state");
          end
          3'd4: pairCmd(lfsr[4] ? 8'h60 : (lfsr[5] ? 8'hFF : 8'h00), blk, 1'b0);
          3'd5: pairCmd(vcode, blk, 1'b1);
          default: pairCmd(vcode, blk, 1'b0);
        endcase
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule